// File: doc/BRIEF.md
# Rotating Interleaved Hub Memory Arbiter

This block shares one memory among a power-of-two number of requester cores. The storage is cut into one bank per core. The banks are interleaved on the lowest address bits, so every word of the address space belongs to exactly one bank.

A free-running rotation counter joins each core to a different bank in every cycle. Over any window of N cycles, each core therefore meets every bank exactly once. A core that asks for a bank outside its current slot is held with a stall until that bank rotates round to it. Reads come back one cycle after the slot with a valid strobe. Writes land in the slot cycle itself.

The block also answers an identity query for each core. It is served in the core's home slot, which is the cycle where the rotation counter equals the core index. The answer is computed from the rotation counter three cycles later. That value is corrected for the pipeline lag and masked to the core count. A core count that is not a power of two is rejected at elaboration.

Top module: `hub_arbiter`

## Requirements
- R1: The bank of a word is its address modulo NCORES, i.e. the low log2(NCORES) address bits. The remaining upper bits select the word inside the bank, so all 2^ADDR_W addresses hold distinct storage.
- R2: The rotation counter is 0 in the first cycle after reset is released and advances by one, modulo NCORES, every cycle. In a cycle with counter value r, core k is joined to bank (r + k) mod NCORES.
- R3: In any cycle at most one core is granted a given bank. Several cores aiming at the same bank are all served, each in its own slot.
- R4: Core k's request is presented with req_valid high and held stable while req_stall is high. If it is first presented in a cycle with counter r0 to bank b, req_stall is high for exactly (b − k − r0) mod NCORES cycles and low in the grant cycle. req_stall is low whenever req_valid is low.
- R5: A granted read (req_we = 0) raises rd_valid for exactly the following cycle, with rd_data holding the addressed word. A granted write never raises rd_valid.
- R6: A write changes the word at the clock edge that ends its grant cycle. Any later read of that address, from any core, returns the new data.
- R7: A one-cycle pulse on id_req[k] while core k has no query outstanding is served in the first later cycle whose counter equals k. id_valid[k] pulses for one cycle three cycles after that grant, with id_value = (counter − 3) AND (NCORES − 1). This value equals k.
- R8: A pulse on id_req[k] while that core's query is pending or in flight is ignored, and yields no second id_valid pulse.
- R9: While reset is asserted, and after it is released with no requests, req_stall, rd_valid and id_valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NCORES | Per-core access request |
| req_we | input | NCORES | Per-core write enable (1 = write) |
| req_addr | input | NCORES*ADDR_W | Per-core word address, core k in slice k |
| req_wdata | input | NCORES*DATA_W | Per-core write data |
| req_stall | output | NCORES | Request held, waiting for its bank slot |
| rd_valid | output | NCORES | Read data strobe, one cycle after grant |
| rd_data | output | NCORES*DATA_W | Per-core read data |
| id_req | input | NCORES | Per-core identity query pulse |
| id_valid | output | NCORES | Identity answer strobe |
| id_value | output | NCORES*max(1,log2 NCORES) | Per-core identity answer |

## Verification
The sweep writes and then reads back every address of a four-core instance, and it predicts each stall length from the rotation phase. A design with a wrong bank-bit choice or a skewed rotation would show the wrong stall count, or would alias two addresses and return stale data. All four cores are also aimed at one bank at the same moment. A crossbar that granted two cores one bank would make the waits collide or corrupt the reads.

Every core asks for its identity several times, and both the value and the exact cycle are checked. An off-by-one lag constant makes the answer one too low: core 0 would report 3 and core 2 would report 1. A second query sent while one is outstanding must not produce a second answer.

// File: rtl/hub_pkg.sv
package hub_pkg;

  // Cycles between the home-slot grant of an identity query and its answer.
  localparam int ID_LAG = 3;

  // Bank that owns a word: low address bits.
  function automatic int addr_bank(int addr, int ncores);
    return addr & (ncores - 1);
  endfunction

  // Word index inside its bank: upper address bits.
  function automatic int addr_line(int addr, int log2n);
    return addr >> log2n;
  endfunction

  // Bank joined to core k when the rotation counter is rot.
  function automatic int slot_bank(int rot, int k, int ncores);
    return (rot + k) & (ncores - 1);
  endfunction

  // Core joined to bank b when the rotation counter is rot.
  function automatic int core_at_bank(int rot, int b, int ncores);
    return (b - rot) & (ncores - 1);
  endfunction

  // Identity answer: counter corrected for the answer lag, masked to the core count.
  function automatic int id_from_rot(int rot, int ncores);
    return (rot - ID_LAG) & (ncores - 1);
  endfunction

endpackage

// File: rtl/hub_rotor.sv
module hub_rotor #(
  parameter int NCORES = 4,
  parameter int CW     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] rot
);

  logic [CW-1:0] rot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rot_q <= '0;
    else        rot_q <= CW'((int'(rot_q) + 1) & (NCORES - 1));
  end

  assign rot = rot_q;

  // R2: the counter moves one step per cycle and wraps at NCORES
  p_rot_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (int'(rot_q) == ((int'($past(rot_q)) + 1) % NCORES)));

endmodule

// File: rtl/hub_bank.sv
module hub_bank #(
  parameter int DEPTH = 64,
  parameter int LW    = 6,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [LW-1:0] line,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[line] <= wdata;
      else    rdata     <= mem[line];
    end
  end

endmodule

// File: rtl/hub_idq.sv
module hub_idq #(
  parameter int NCORES = 4,
  parameter int CW     = 2,
  parameter int K      = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] rot,
  input  logic          id_req,
  output logic          id_valid,
  output logic [CW-1:0] id_value
);
  import hub_pkg::*;

  logic                pend_q;
  logic [ID_LAG-1:0]   stg_q;
  logic                busy;
  logic                home_slot;
  logic                id_grant;

  assign busy      = pend_q | (|stg_q);
  assign home_slot = (int'(rot) == K);
  assign id_grant  = pend_q & home_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      stg_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~id_grant) | (id_req & ~busy);
      stg_q  <= {stg_q[ID_LAG-2:0], id_grant};
    end
  end

  assign id_valid = stg_q[ID_LAG-1];
  assign id_value = CW'(id_from_rot(int'(rot), NCORES));

  // R7: the answer, taken from the shared counter, is this instance's own index
  p_id_own_r7: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |-> (int'(id_value) == K));

  // R8: only one query in flight, so answers never come back to back
  p_id_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> !id_valid);

endmodule

// File: rtl/hub_arbiter.sv
module hub_arbiter #(
  parameter int NCORES = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NCORES-1:0]           req_valid,
  input  logic [NCORES-1:0]           req_we,
  input  logic [NCORES*ADDR_W-1:0]    req_addr,
  input  logic [NCORES*DATA_W-1:0]    req_wdata,
  output logic [NCORES-1:0]           req_stall,
  output logic [NCORES-1:0]           rd_valid,
  output logic [NCORES*DATA_W-1:0]    rd_data,
  input  logic [NCORES-1:0]           id_req,
  output logic [NCORES-1:0]           id_valid,
  output logic [NCORES*((NCORES > 1) ? $clog2(NCORES) : 1)-1:0] id_value
);
  import hub_pkg::*;

  localparam int LOG2N = $clog2(NCORES);
  localparam int CW    = (LOG2N > 0) ? LOG2N : 1;
  localparam int LW    = ADDR_W - LOG2N;
  localparam int DEPTH = 1 << LW;

  if (NCORES < 1 || (NCORES & (NCORES - 1)) != 0) begin : g_bad_ncores
    $error("hub_arbiter: NCORES must be a power of two");
  end
  if (LOG2N >= ADDR_W) begin : g_bad_addr
    $error("hub_arbiter: ADDR_W too small for NCORES banks");
  end

  logic [CW-1:0]     rot;
  logic [ADDR_W-1:0] addr_a   [NCORES];
  logic [DATA_W-1:0] wdata_a  [NCORES];
  logic [CW-1:0]     tgt_bank [NCORES];
  logic [CW-1:0]     my_slot  [NCORES];
  logic [NCORES-1:0] grant;
  logic [CW-1:0]     rdb_q    [NCORES];
  logic [NCORES-1:0] rdv_q;
  logic [CW+1:0]     wcnt_q   [NCORES];

  logic [CW-1:0]     src_core [NCORES];
  logic [NCORES-1:0] b_en;
  logic [NCORES-1:0] b_we;
  logic [LW-1:0]     b_line   [NCORES];
  logic [DATA_W-1:0] b_wdata  [NCORES];
  logic [DATA_W-1:0] b_rdata  [NCORES];
  logic [NCORES-1:0] bank_hit [NCORES];

  hub_rotor #(.NCORES(NCORES), .CW(CW)) u_rotor (
    .clk   (clk),
    .rst_n (rst_n),
    .rot   (rot)
  );

  // Requester side: slot match, stall, read return, identity query
  for (genvar k = 0; k < NCORES; k++) begin : g_core
    assign addr_a[k]   = req_addr[k*ADDR_W +: ADDR_W];
    assign wdata_a[k]  = req_wdata[k*DATA_W +: DATA_W];
    assign tgt_bank[k] = CW'(addr_bank(int'(addr_a[k]), NCORES));
    assign my_slot[k]  = CW'(slot_bank(int'(rot), k, NCORES));
    assign grant[k]    = req_valid[k] && (tgt_bank[k] == my_slot[k]);
    assign req_stall[k] = req_valid[k] & ~grant[k];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rdv_q[k]  <= 1'b0;
        rdb_q[k]  <= '0;
        wcnt_q[k] <= '0;
      end else begin
        rdv_q[k]  <= grant[k] & ~req_we[k];
        rdb_q[k]  <= tgt_bank[k];
        wcnt_q[k] <= req_stall[k] ? wcnt_q[k] + 1'b1 : '0;
      end
    end

    assign rd_valid[k]                 = rdv_q[k];
    assign rd_data[k*DATA_W +: DATA_W] = b_rdata[rdb_q[k]];

    hub_idq #(.NCORES(NCORES), .CW(CW), .K(k)) u_idq (
      .clk      (clk),
      .rst_n    (rst_n),
      .rot      (rot),
      .id_req   (id_req[k]),
      .id_valid (id_valid[k]),
      .id_value (id_value[k*CW +: CW])
    );

    // R4: a held request waits fewer than NCORES cycles for its slot
    p_stall_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_stall[k] |-> (wcnt_q[k] < (CW+2)'(NCORES - 1)));

    // R5: read data only follows a read that was granted the cycle before
    p_rd_after_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && rd_valid[k] |-> $past(req_valid[k] & ~req_we[k] & ~req_stall[k]));
  end

  // Bank side: each bank takes the one core the rotation joins to it
  for (genvar b = 0; b < NCORES; b++) begin : g_bank
    assign src_core[b] = CW'(core_at_bank(int'(rot), b, NCORES));
    assign b_en[b]     = grant[src_core[b]];
    assign b_we[b]     = req_we[src_core[b]];
    assign b_line[b]   = LW'(addr_line(int'(addr_a[src_core[b]]), LOG2N));
    assign b_wdata[b]  = wdata_a[src_core[b]];

    hub_bank #(.DEPTH(DEPTH), .LW(LW), .DW(DATA_W)) u_bank (
      .clk   (clk),
      .en    (b_en[b]),
      .we    (b_we[b]),
      .line  (b_line[b]),
      .wdata (b_wdata[b]),
      .rdata (b_rdata[b])
    );

    always_comb begin
      for (int k = 0; k < NCORES; k++)
        bank_hit[b][k] = grant[k] && (int'(tgt_bank[k]) == b);
    end

    // R3: no two cores are granted the same bank in one cycle
    p_one_core_per_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_hit[b]));
  end

endmodule

// File: tb/tb_hub_arbiter.sv
module tb_hub_arbiter;
  localparam int N  = 4;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int CW = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [N-1:0]    req_we = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N*DW-1:0] req_wdata = '0;
  logic [N-1:0]    req_stall;
  logic [N-1:0]    rd_valid;
  logic [N*DW-1:0] rd_data;
  logic [N-1:0]    id_req = '0;
  logic [N-1:0]    id_valid;
  logic [N*CW-1:0] id_value;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  hub_arbiter #(.NCORES(N), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_stall(req_stall),
    .rd_valid(rd_valid), .rd_data(rd_data), .id_req(id_req),
    .id_valid(id_valid), .id_value(id_value)
  );

  always #2 clk = ~clk;

  // Bench copy of the phase: counter value equals cyc mod N (R2)
  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  task automatic check(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] pat(int a, int salt);
    return DW'(a * 40503 + salt * 7919) ^ 16'h5A3C;
  endfunction

  // One access from core k; checks stall length (R2, R4) and read return (R5, R6, R1)
  task automatic access(int k, int a, bit we, logic [DW-1:0] wd, logic [DW-1:0] expd);
    int rot0, w, waited;
    @(negedge clk);
    rot0 = cyc % N;
    req_valid[k] = 1'b1;
    req_we[k] = we;
    req_addr[k*AW +: AW] = AW'(a);
    req_wdata[k*DW +: DW] = wd;
    w = (((a % N) - k - rot0) % N + 2 * N) % N;
    waited = 0;
    #1;
    while (req_stall[k] && waited <= N + 2) begin
      waited++;
      @(negedge clk);
      #1;
    end
    check(waited == w, "R2 R4 stall length", waited, w);
    @(negedge clk);
    req_valid[k] = 1'b0;
    #1;
    if (we) begin
      check(rd_valid[k] == 1'b0, "R5 write gives no rd_valid", int'(rd_valid[k]), 0);
    end else begin
      check(rd_valid[k] == 1'b1, "R5 rd_valid after grant", int'(rd_valid[k]), 1);
      check(rd_data[k*DW +: DW] == expd, "R1 R6 read data",
            int'(rd_data[k*DW +: DW]), int'(expd));
      @(negedge clk);
      #1;
      check(rd_valid[k] == 1'b0, "R5 rd_valid one cycle", int'(rd_valid[k]), 0);
    end
  endtask

  // Identity query on core k: value and exact cycle (R7)
  task automatic id_check(int k);
    int c0, cg, n;
    @(negedge clk);
    c0 = cyc;
    id_req[k] = 1'b1;
    @(negedge clk);
    id_req[k] = 1'b0;
    cg = c0 + 1;
    while (cg % N != k) cg++;
    n = 0;
    #1;
    while (!id_valid[k] && n < 40) begin
      @(negedge clk);
      #1;
      n++;
    end
    check(cyc == cg + 3, "R7 answer cycle", cyc, cg + 3);
    check(id_value[k*CW +: CW] == CW'(k), "R7 own id",
          int'(id_value[k*CW +: CW]), k);
    @(negedge clk);
    #1;
    check(id_valid[k] == 1'b0, "R7 id_valid one cycle", int'(id_valid[k]), 0);
  endtask

  // Repeated pulses while busy give one answer only (R8)
  task automatic id_busy(int k);
    int pulses;
    pulses = 0;
    @(negedge clk);
    id_req[k] = 1'b1;
    for (int i = 0; i < 2 * N + 8; i++) begin
      @(negedge clk);
      id_req[k] = (i < 3);
      #1;
      if (id_valid[k]) pulses++;
    end
    id_req[k] = 1'b0;
    check(pulses == 1, "R8 single answer", pulses, 1);
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(req_stall == '0, "R9 stall in reset", int'(req_stall), 0);
    check(rd_valid == '0, "R9 rd_valid in reset", int'(rd_valid), 0);
    check(id_valid == '0, "R9 id_valid in reset", int'(id_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check(req_stall == '0, "R4 R9 idle stall", int'(req_stall), 0);
    check(rd_valid == '0, "R9 idle rd_valid", int'(rd_valid), 0);
    check(id_valid == '0, "R9 idle id_valid", int'(id_valid), 0);

    // Fill every address from varying cores, then read all back from others
    for (int a = 0; a < (1 << AW); a++)
      access((a * 3 + a / 4) % N, a, 1'b1, pat(a, 1), '0);
    for (int a = 0; a < (1 << AW); a++)
      access((a + 1) % N, a, 1'b0, '0, pat(a, 1));

    // All cores aim at one bank at once (R3)
    for (int rep = 0; rep < N; rep++) begin
      for (int k = 0; k < N; k++) begin
        automatic int kk = k;
        automatic int aa = rep + N * (kk + 2 * rep + 1);
        fork
          access(kk, aa, 1'b0, '0, pat(aa, 1));
        join_none
      end
      wait fork;
    end

    // Parallel writes to one bank, then parallel read-back (R3, R6)
    for (int k = 0; k < N; k++) begin
      automatic int kk = k;
      fork
        access(kk, 2 + N * (kk + 5), 1'b1, pat(kk, 9), '0);
      join_none
    end
    wait fork;
    for (int k = 0; k < N; k++) begin
      automatic int kk = k;
      fork
        access((kk + 1) % N, 2 + N * (kk + 5), 1'b0, '0, pat(kk, 9));
      join_none
    end
    wait fork;

    // Overwrite then read immediately from a different core (R6)
    for (int a = 0; a < 24; a++) begin
      access(a % N, a * 11 % 256, 1'b1, pat(a, 3), '0);
      access((a + 2) % N, a * 11 % 256, 1'b0, '0, pat(a, 3));
    end

    // Identity queries from every core, at different phases (R7, R8)
    for (int rep = 0; rep < 3; rep++) begin
      for (int k = 0; k < N; k++) begin
        id_check(k);
        repeat (rep) @(negedge clk);
      end
    end
    for (int k = 0; k < N; k++) id_busy(k);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule